// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block is a serial port for attaching converters, codecs or a second port to a chip. A transmitter and a receiver share a bit clock that the block divides down from the system clock. Parallel words enter on a valid/ready handshake and leave on a one-cycle valid strobe. Each word is shifted most significant bit first, and its length can be set from 8 to 16 bits.

Each word is marked by a frame sync, and the sync has two shapes. In normal framing, a sync lasting one bit period comes just before the data. In alternate framing, the sync is held for the whole word and falls after the last bit, so its falling edge can latch a word into an external converter. Either sync can be active-high or inverted. The receive sync can come from an input pin or from an internal divider that opens a sampling frame at a fixed rate. The receiver can also run from an external bit clock, which the block samples and synchronises to the system clock.

Top module: `fsport`

## Requirements
- R1: After reset `sclk_o` is low. It then toggles every `cfg_sclk_div`+1 system cycles, so one bit period lasts 2×(`cfg_sclk_div`+1) cycles.
- R2: `tfs_o`, `dt_o` and `rfs_o` change only in the system cycle after `sclk_o` rises. The receiver samples its inputs when the bit clock falls.
- R3: Normal framing (`cfg_tx_alt`=0): the transmit sync is active for exactly one bit period. The N data bits then follow, most significant bit first, in the next N periods, where N = `cfg_wlen_m1`+1.
- R4: Normal framing, with a word already waiting: the next sync is driven in the period right after the last data bit. The inactive gap between two syncs is therefore exactly N periods.
- R5: Alternate framing (`cfg_tx_alt`=1): the sync becomes active together with the first data bit, stays active for exactly N periods, and goes inactive after the last bit.
- R6: Alternate framing: consecutive words are separated by at least one idle bit period. When a word is already waiting, the gap is exactly one period.
- R7: `cfg_wlen_m1` sets the word length to its value plus one. Values 7 to 15 give lengths of 8 to 16 bits, and values below 7 behave as 7.
- R8: A received word appears on `rx_data` right-justified, with all bits above the word length at zero. `rx_valid` is high for exactly one system cycle per word.
- R9: With the inversion flag at 1, a sync pin is active-low and idles high. With the flag at 0 it is active-high and idles low. `cfg_tfs_inv` sets the polarity of `tfs_o`, and `cfg_rfs_inv` sets the polarity of `rfs_i` and `rfs_o`.
- R10: With `cfg_rfs_int`=1, the receiver uses an internal sync. In normal framing this sync is active for one bit period every `cfg_rfs_div`+1 periods, and it is driven on `rfs_o`.
- R11: With `cfg_rx_ext_clk`=1, the receiver samples `dr_i` and `rfs_i` on falling edges of `sclk_i`. An inverted alternate sync with 16-bit words, whose two top bits are zero, delivers the word unchanged.
- R12: After reset, `tx_ready`=1 and `rx_valid`=0. One word can wait in a holding register while another is in flight, and `tx_ready` is 0 while that register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sclk_div | input | DIVW | Bit-clock divisor |
| cfg_rfs_div | input | RFSW | Internal receive-sync period minus one, in bit periods |
| cfg_wlen_m1 | input | $clog2(DW) | Word length minus one |
| cfg_tx_alt | input | 1 | Transmit alternate framing |
| cfg_rx_alt | input | 1 | Receive alternate framing |
| cfg_tfs_inv | input | 1 | Transmit sync active-low |
| cfg_rfs_inv | input | 1 | Receive sync active-low |
| cfg_rfs_int | input | 1 | Receive sync from internal divider |
| cfg_rx_ext_clk | input | 1 | Receiver uses `sclk_i` |
| tx_data | input | DW | Word to send |
| tx_valid | input | 1 | `tx_data` valid |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | DW | Received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk_o | output | 1 | Internal bit clock |
| tfs_o | output | 1 | Transmit frame sync |
| dt_o | output | 1 | Transmit serial data |
| rfs_o | output | 1 | Internal receive sync |
| sclk_i | input | 1 | External bit clock |
| rfs_i | input | 1 | External receive sync |
| dr_i | input | 1 | Receive serial data |

## Verification
Random words are sent through a loopback of `dt_o` and `tfs_o` in both framing modes, with both polarities and several word lengths. This shows up swapped bit order, a wrong length, lost zero fill and a wrong polarity. The transmit stream is fed without pause, so the spacing between syncs separates the back-to-back behaviour of normal framing from the mandatory idle period of alternate framing. Separate runs measure the bit-clock period and the internal sync spacing, including the divisor of 255. A directed run drives an external bit clock with an inverted, held sync carrying zero-padded 14-bit samples.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SYNC, TX_DATA} tx_st_t;
  typedef enum logic {RX_IDLE, RX_DATA} rx_st_t;
endpackage

// File: rtl/fsp_sclk_gen.sv
module fsp_sclk_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div,
  output logic            sclk,
  output logic            rise,
  output logic            fall
);
  logic [DIVW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (cnt == div) begin
        cnt  <= '0;
        sclk <= ~sclk;
        rise <= ~sclk;
        fall <= sclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx
  import fsp_pkg::*;
#(
  parameter int DW = 16,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          alt,
  input  logic          inv,
  input  logic [IW-1:0] wl,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          tfs_o,
  output logic          dt_o
);
  tx_st_t        st;
  logic [DW-1:0] hold_q, word_q;
  logic          hold_v;
  logic [IW-1:0] bit_q;

  assign tx_ready = ~hold_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_IDLE;
      hold_q <= '0;
      hold_v <= 1'b0;
      word_q <= '0;
      bit_q  <= '0;
      tfs_o  <= inv;
      dt_o   <= 1'b0;
    end else begin
      if (tx_valid && !hold_v) begin
        hold_q <= tx_data;
        hold_v <= 1'b1;
      end
      if (rise) begin
        unique case (st)
          TX_IDLE: begin
            if (hold_v) begin
              word_q <= hold_q;
              hold_v <= 1'b0;
              tfs_o  <= ~inv;
              if (alt) begin
                dt_o  <= hold_q[wl];
                bit_q <= wl;
                st    <= TX_DATA;
              end else begin
                dt_o <= 1'b0;
                st   <= TX_SYNC;
              end
            end else begin
              tfs_o <= inv;
              dt_o  <= 1'b0;
            end
          end
          TX_SYNC: begin
            tfs_o <= inv;
            dt_o  <= word_q[wl];
            bit_q <= wl;
            st    <= TX_DATA;
          end
          TX_DATA: begin
            if (bit_q != '0) begin
              bit_q <= bit_q - 1'b1;
              dt_o  <= word_q[bit_q-1'b1];
            end else if (!alt && hold_v) begin
              word_q <= hold_q;
              hold_v <= 1'b0;
              tfs_o  <= ~inv;
              dt_o   <= 1'b0;
              st     <= TX_SYNC;
            end else begin
              tfs_o <= inv;
              dt_o  <= 1'b0;
              st    <= TX_IDLE;
            end
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsp_rfs_gen.sv
module fsp_rfs_gen #(
  parameter int RFSW = 12,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise,
  input  logic [RFSW-1:0] div,
  input  logic            alt,
  input  logic            inv,
  input  logic [IW-1:0]   wl,
  output logic            act,
  output logic            pin
);
  logic [RFSW-1:0] cnt;
  logic            nxt;

  always_comb begin
    if (alt) nxt = (cnt <= RFSW'(wl));
    else     nxt = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      act <= 1'b0;
      pin <= inv;
    end else if (rise) begin
      act <= nxt;
      pin <= nxt ^ inv;
      cnt <= (cnt == div) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx
  import fsp_pkg::*;
#(
  parameter int DW = 16,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_clk,
  input  logic          fall_int,
  input  logic          sclk_i,
  input  logic          rfs_i,
  input  logic          dr_i,
  input  logic          use_int_rfs,
  input  logic          int_rfs_act,
  input  logic          inv,
  input  logic          alt,
  input  logic [IW-1:0] wl,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid
);
  logic [2:0]    s_clk;
  logic [1:0]    s_fs, s_dr;
  rx_st_t        st;
  logic [DW-1:0] sh, nsh;
  logic [IW-1:0] cnt;
  logic          samp, bit_in, sync_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_clk <= '0;
      s_fs  <= '0;
      s_dr  <= '0;
    end else begin
      s_clk <= {s_clk[1:0], sclk_i};
      s_fs  <= {s_fs[0], rfs_i};
      s_dr  <= {s_dr[0], dr_i};
    end
  end

  always_comb begin
    samp     = ext_clk ? (s_clk[2] & ~s_clk[1]) : fall_int;
    bit_in   = ext_clk ? s_dr[1] : dr_i;
    sync_act = use_int_rfs ? int_rfs_act : ((ext_clk ? s_fs[1] : rfs_i) ^ inv);
    nsh      = {sh[DW-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      sh       <= '0;
      cnt      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (samp) begin
        unique case (st)
          RX_IDLE: begin
            if (sync_act) begin
              st <= RX_DATA;
              if (alt) begin
                sh  <= DW'(bit_in);
                cnt <= IW'(1);
              end else begin
                sh  <= '0;
                cnt <= '0;
              end
            end
          end
          RX_DATA: begin
            if (cnt == wl) begin
              rx_data  <= nsh;
              rx_valid <= 1'b1;
              sh       <= '0;
              cnt      <= '0;
              st       <= (!alt && sync_act) ? RX_DATA : RX_IDLE;
            end else begin
              sh  <= nsh;
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsport.sv
module fsport #(
  parameter int DW   = 16,
  parameter int MINW = 8,
  parameter int DIVW = 8,
  parameter int RFSW = 12,
  localparam int IW  = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] cfg_sclk_div,
  input  logic [RFSW-1:0] cfg_rfs_div,
  input  logic [IW-1:0]   cfg_wlen_m1,
  input  logic            cfg_tx_alt,
  input  logic            cfg_rx_alt,
  input  logic            cfg_tfs_inv,
  input  logic            cfg_rfs_inv,
  input  logic            cfg_rfs_int,
  input  logic            cfg_rx_ext_clk,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [DW-1:0]   rx_data,
  output logic            rx_valid,
  output logic            sclk_o,
  output logic            tfs_o,
  output logic            dt_o,
  output logic            rfs_o,
  input  logic            sclk_i,
  input  logic            rfs_i,
  input  logic            dr_i
);
  localparam logic [IW-1:0] WMIN = IW'(MINW - 1);

  logic [IW-1:0] wl;
  logic          rise, fall, int_act;

  assign wl = (cfg_wlen_m1 < WMIN) ? WMIN : cfg_wlen_m1;

  fsp_sclk_gen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst(rst), .div(cfg_sclk_div),
    .sclk(sclk_o), .rise(rise), .fall(fall)
  );

  fsp_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .rise(rise), .alt(cfg_tx_alt), .inv(cfg_tfs_inv),
    .wl(wl), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tfs_o(tfs_o), .dt_o(dt_o)
  );

  fsp_rfs_gen #(.RFSW(RFSW), .IW(IW)) u_rfs (
    .clk(clk), .rst(rst), .rise(rise), .div(cfg_rfs_div), .alt(cfg_rx_alt),
    .inv(cfg_rfs_inv), .wl(wl), .act(int_act), .pin(rfs_o)
  );

  fsp_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .ext_clk(cfg_rx_ext_clk), .fall_int(fall),
    .sclk_i(sclk_i), .rfs_i(rfs_i), .dr_i(dr_i), .use_int_rfs(cfg_rfs_int),
    .int_rfs_act(int_act), .inv(cfg_rfs_inv), .alt(cfg_rx_alt), .wl(wl),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int DW   = 16,
  parameter int DIVW = 8,
  localparam int IW  = $clog2(DW)
) (
  input logic            clk,
  input logic            rst,
  input logic [DIVW-1:0] cfg_sclk_div,
  input logic [IW-1:0]   cfg_wlen_m1,
  input logic            sclk_o,
  input logic            tfs_o,
  input logic            dt_o,
  input logic            rfs_o,
  input logic            rx_valid,
  input logic [DW-1:0]   rx_data
);
  logic [DIVW:0]   run;
  logic [IW-1:0]   wlc;

  assign wlc = (cfg_wlen_m1 < IW'(7)) ? IW'(7) : cfg_wlen_m1;

  always_ff @(posedge clk) begin
    if (rst)                  run <= '0;
    else if (!$stable(sclk_o)) run <= (DIVW+1)'(1);
    else                      run <= run + 1'b1;
  end

  p_sclk_half_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk_o) |-> run == (DIVW+1)'(cfg_sclk_div) + 1'b1);

  p_tfs_edge_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(tfs_o) |-> ($past(sclk_o) && !$past(sclk_o, 2)));

  p_dt_edge_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(dt_o) |-> ($past(sclk_o) && !$past(sclk_o, 2)));

  p_rfs_edge_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(rfs_o) |-> ($past(sclk_o) && !$past(sclk_o, 2)));

  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_zero_fill_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> wlc) >> 1) == '0);
endmodule

bind fsport fsp_chk #(.DW(DW), .DIVW(DIVW)) u_chk (
  .clk(clk), .rst(rst), .cfg_sclk_div(cfg_sclk_div), .cfg_wlen_m1(cfg_wlen_m1),
  .sclk_o(sclk_o), .tfs_o(tfs_o), .dt_o(dt_o), .rfs_o(rfs_o),
  .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/sim_fsport.sv
`timescale 1ns/1ps
module sim_fsport;
  logic        clk = 0, rst = 1;
  logic [7:0]  sdiv = 1;
  logic [11:0] rdiv = 0;
  logic [3:0]  wlm1 = 7;
  logic        txalt = 0, rxalt = 0, tinv = 0, rinv = 0, rint = 0, rext = 0;
  logic [15:0] txd = 0;
  logic        txv = 0;
  logic        txr, rxv, sclk, tfs, dt, rfso;
  logic [15:0] rxd;
  logic        b_sclk = 0, b_rfs = 1, b_dr = 0, ext_mode = 0;
  logic        rfsi, dri;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_w [0:31];
  int rcv = 0, n_exp = 0;
  bit collect = 0;
  string cur_req = "R3";

  bit mon_en = 0, mon_alt = 0, mon_inv = 0;
  int mon_wl = 7;
  bit m_prev = 0, m_seen = 0;
  int m_run = 0, m_gap = 0;
  logic s_p1 = 0, s_p2 = 0, tfs_p = 0, dt_p = 0;

  always #10 clk = ~clk;

  assign rfsi = ext_mode ? b_rfs : tfs;
  assign dri  = ext_mode ? b_dr  : dt;

  fsport u0 (
    .clk(clk), .rst(rst), .cfg_sclk_div(sdiv), .cfg_rfs_div(rdiv),
    .cfg_wlen_m1(wlm1), .cfg_tx_alt(txalt), .cfg_rx_alt(rxalt),
    .cfg_tfs_inv(tinv), .cfg_rfs_inv(rinv), .cfg_rfs_int(rint),
    .cfg_rx_ext_clk(rext), .tx_data(txd), .tx_valid(txv), .tx_ready(txr),
    .rx_data(rxd), .rx_valid(rxv), .sclk_o(sclk), .tfs_o(tfs), .dt_o(dt),
    .rfs_o(rfso), .sclk_i(b_sclk), .rfs_i(rfsi), .dr_i(dri)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_w(input logic [15:0] w, input int wl);
    return w & 16'((32'd1 << (wl + 1)) - 1);
  endfunction

  always @(negedge clk) begin
    if (collect && rxv) begin
      if (rcv < n_exp) chk(rxd == exp_w[rcv], cur_req, rxd, exp_w[rcv]);
      else chk(0, cur_req, rxd, 0);
      rcv++;
    end
  end

  always @(negedge clk) begin
    bit a;
    if (!mon_en) begin
      m_prev = 0; m_seen = 0; m_run = 0; m_gap = 0;
    end else begin
      if (tfs !== tfs_p || dt !== dt_p)
        chk(sclk && s_p1 && !s_p2, "R2", {s_p2, s_p1, sclk}, 3'b011);
      if (s_p1 && !sclk) begin
        a = tfs ^ mon_inv;
        if (a) begin
          if (!m_prev) begin
            if (m_seen) chk(m_gap == (mon_alt ? 1 : mon_wl + 1), mon_alt ? "R6" : "R4",
                            m_gap, mon_alt ? 1 : mon_wl + 1);
            m_run = 0;
          end
          m_run++;
        end else begin
          if (m_prev) begin
            chk(m_run == (mon_alt ? mon_wl + 1 : 1), mon_alt ? "R5 R9" : "R3 R9",
                m_run, mon_alt ? mon_wl + 1 : 1);
            m_seen = 1; m_gap = 0;
          end
          m_gap++;
        end
        m_prev = a;
      end
    end
    s_p2 = s_p1; s_p1 = sclk; tfs_p = tfs; dt_p = dt;
  end

  task automatic apply();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(sclk == 0, "R1", sclk, 0);
    chk(txr == 1, "R12", txr, 1);
    chk(rxv == 0, "R12", rxv, 0);
    chk(tfs == tinv, "R9", tfs, tinv);
  endtask

  task automatic lb_test(input bit alt, input bit inv, input int wl, input int n, input int div);
    sdiv = 8'(div); wlm1 = 4'(wl); txalt = alt; rxalt = alt; tinv = inv; rinv = inv;
    rint = 0; rext = 0; ext_mode = 0;
    apply();
    mon_alt = alt; mon_inv = inv; mon_wl = wl; mon_en = 1;
    rcv = 0; n_exp = 0; collect = 1;
    cur_req = alt ? "R5 R7 R8" : "R3 R7 R8";
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      exp_w[n_exp] = mask_w(w, wl); n_exp++;
      while (!txr) @(negedge clk);
      txd = w; txv = 1;
      @(negedge clk);
      txv = 0;
      chk(txr == 0, "R12", txr, 0);
    end
    repeat ((wl + 5) * 4 * (div + 1)) @(negedge clk);
    chk(rcv == n, alt ? "R5" : "R3", rcv, n);
    mon_en = 0; collect = 0;
  endtask

  task automatic clk_test(input int div);
    int c;
    sdiv = 8'(div); apply();
    while (!sclk) @(negedge clk);
    while (sclk) @(negedge clk);
    while (!sclk) @(negedge clk);
    c = 0;
    while (sclk) begin c++; @(negedge clk); end
    while (!sclk) begin c++; @(negedge clk); end
    chk(c == 2 * (div + 1), "R1", c, 2 * (div + 1));
  endtask

  task automatic rfs_test(input int div, input bit inv);
    int idx, last, k, run;
    bit pa, a;
    sdiv = 1; rdiv = 12'(div); rint = 1; rinv = inv; rxalt = 0; rext = 0; ext_mode = 0;
    apply();
    chk(rfso == inv, "R9", rfso, inv);
    idx = 0; last = -1; k = 0; pa = 0; run = 0;
    while (k < 3) begin
      @(negedge clk);
      if (s_p1 && !sclk) begin
        a = rfso ^ inv;
        if (a) run++;
        if (a && !pa) begin
          if (last >= 0) begin
            chk(idx - last == div + 1, "R10", idx - last, div + 1);
            k++;
          end
          last = idx;
        end
        if (!a && pa) begin chk(run == 1, "R10", run, 1); run = 0; end
        pa = a; idx++;
      end
    end
    rint = 0;
  endtask

  task automatic ext_test();
    sdiv = 1; wlm1 = 15; rxalt = 1; rinv = 1; rint = 0; rext = 1; ext_mode = 1;
    b_rfs = 1; b_sclk = 0;
    apply();
    rcv = 0; n_exp = 0; collect = 1; cur_req = "R8 R11";
    for (int k = 0; k < 3; k++) begin
      logic [15:0] w;
      w = {2'b00, 14'($urandom)};
      exp_w[n_exp] = w; n_exp++;
      for (int b = -2; b < 18; b++) begin
        @(negedge clk);
        b_sclk = 1;
        b_rfs  = !(b >= 0 && b < 16);
        b_dr   = (b >= 0 && b < 16) ? w[15 - b] : 1'b0;
        repeat (4) @(negedge clk);
        b_sclk = 0;
        repeat (3) @(negedge clk);
      end
    end
    repeat (20) @(negedge clk);
    chk(rcv == 3, "R11", rcv, 3);
    collect = 0; ext_mode = 0; rext = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clk_test(1);
    clk_test(2);
    clk_test(5);
    lb_test(0, 0, 7, 10, 1);
    lb_test(0, 1, 15, 10, 1);
    lb_test(1, 0, 15, 10, 1);
    lb_test(1, 1, 7, 10, 2);
    for (int r = 0; r < 4; r++)
      lb_test(r[0], r[1], 8 + int'($urandom % 7), 8, 1 + int'($urandom % 3));
    rfs_test(19, 0);
    rfs_test(255, 1);
    ext_test();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule